// File: doc/BRIEF.md
# Channel Mode and Supply Controller

This block decides, for one bus channel, whether the physical layer runs in normal, standby or unpowered operation. It looks at a standby request pin and at two supply undervoltage flags (one for the core/driver supply, one for the digital I/O supply), resynchronises all three into its clock domain and runs a small state machine over them. The chosen mode is published on a two-bit output together with the enables that the surrounding transmitter, bias generator and receive pin buffer need.

In normal mode the receive pin follows the differential receiver and the transmit driver path is enabled. In standby the driver path is cut, so transmit data has no effect, the bias is off and the receive pin is handed to the wake-up detector: it idles high through the pull-up and is actively pulled low only while the detector reports a low level. A core undervoltage keeps the channel in standby with wake reporting still working, while an I/O undervoltage drops the channel into the unpowered state where every enable is off. Leaving standby passes through a counted settling interval, and leaving the unpowered state waits out a counted power-up delay.

Top module: `chan_mode_ctrl`

## Requirements
- R1: The mode output encodes unpowered as 0, standby as 1, settling as 2 and normal as 3; once the inputs have been steady long enough, the mode is unpowered if the I/O undervoltage flag is high, otherwise standby if the core undervoltage flag or the standby request is high, otherwise normal.
- R2: In normal mode the driver enable, the bias enable and the push-pull enable are all 1 and the receive output equals the receiver level (1 recessive, 0 dominant).
- R3: In standby the driver enable and the bias enable are 0, the receive output equals the wake-report level, and the push-pull enable is 1 only while the wake-report level is 0.
- R4: A high core undervoltage flag keeps the channel in standby even with the standby request low, and the wake-report level still reaches the receive output.
- R5: In the unpowered mode the driver, bias and push-pull enables are 0 and the receive output is 1, whatever the receiver and wake-report levels.
- R6: A standby-to-normal change passes through the settling mode for exactly SETTLE_CYC clock cycles; during settling the driver enable is 0, the bias enable is 1, the push-pull enable is 0 and the receive output is 1.
- R7: A standby request or core undervoltage arriving during settling returns the channel to standby without ever reaching normal.
- R8: After reset, and after the I/O undervoltage flag clears, the channel stays unpowered for PWRUP_CYC cycles once the cleared flag is seen, then enters standby.
- R9: Each of the three control inputs passes through a two-flop synchroniser, so a change applied before clock edge k first alters the mode at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request, 1 selects standby |
| core_uv | input | 1 | Core supply undervoltage flag |
| io_uv | input | 1 | I/O supply undervoltage flag |
| rx_level | input | 1 | Differential receiver level, 1 recessive |
| wake_level | input | 1 | Receive level reported by the wake-up detector |
| mode | output | 2 | Current mode (0 unpowered, 1 standby, 2 settling, 3 normal) |
| drv_en | output | 1 | Transmit driver path enable |
| bias_en | output | 1 | Bus bias enable |
| rxd_out | output | 1 | Value for the receive pin |
| rxd_pp_en | output | 1 | Push-pull drive enable for the receive pin |

## Verification
All eight combinations of the two undervoltage flags and the standby request are applied from normal mode, and in each resulting mode all four combinations of receiver and wake levels are applied, which separates the priority order and shows which source owns the receive pin. Edge-exact checks around the synchroniser latency, the last settling cycle and the last power-up cycle tell an off-by-one counter or a missing flop apart from a correct one. Settling is also interrupted both by the standby request and by a core undervoltage to show that normal is never reached early.

// File: rtl/chan_mode_pkg.sv
package chan_mode_pkg;

  typedef enum logic [1:0] {
    MODE_UNPWR  = 2'd0,
    MODE_STBY   = 2'd1,
    MODE_SETTLE = 2'd2,
    MODE_NORM   = 2'd3
  } mode_t;

  // Mode the channel heads for, given the resynchronised controls.
  function automatic mode_t target_mode(input logic io_low, input logic core_low,
                                        input logic stby);
    if (io_low)              return MODE_UNPWR;
    else if (core_low || stby) return MODE_STBY;
    else                     return MODE_NORM;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cm_sync2.sv
module cm_sync2 #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/cm_mode_fsm.sv
module cm_mode_fsm
  import chan_mode_pkg::*;
#(
  parameter int unsigned PWRUP_CYC  = 15000,
  parameter int unsigned SETTLE_CYC = 2000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_io_uv,
  input  logic  s_core_uv,
  input  logic  s_stby,
  output mode_t mode_q
);
  localparam int unsigned CNT_MAX = max2(PWRUP_CYC, SETTLE_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(SETTLE_CYC - 1);

  mode_t            mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             leave_stby;

  assign leave_stby = (target_mode(s_io_uv, s_core_uv, s_stby) == MODE_NORM);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_UNPWR: begin
        if (cnt_q == PW_LAST) begin
          mode_d = MODE_STBY;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      MODE_STBY: begin
        if (leave_stby) begin
          mode_d = MODE_SETTLE;
          cnt_d  = '0;
        end
      end
      MODE_SETTLE: begin
        if (!leave_stby) begin
          mode_d = MODE_STBY;
          cnt_d  = '0;
        end else if (cnt_q == ST_LAST) begin
          mode_d = MODE_NORM;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      MODE_NORM: begin
        if (!leave_stby) mode_d = MODE_STBY;
      end
      default: mode_d = MODE_UNPWR;
    endcase
    if (s_io_uv) begin
      mode_d = MODE_UNPWR;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_UNPWR;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: a seen I/O undervoltage always lands in the unpowered mode
  assert_io_uv_unpwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_io_uv |=> mode_q == MODE_UNPWR);

  // R4: a seen core undervoltage never allows settling or normal next
  assert_core_uv_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_core_uv |=> (mode_q == MODE_UNPWR || mode_q == MODE_STBY));

  // R6: normal is only ever entered from settling
  assert_norm_via_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORM && $past(mode_q) != MODE_NORM) |-> $past(mode_q) == MODE_SETTLE);

  // R8: standby is entered from unpowered only at the end of the power-up count
  assert_pwrup_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STBY && $past(mode_q) == MODE_UNPWR) |-> $past(cnt_q) == PW_LAST);

  // R6: the settling counter never passes its last value
  assert_settle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == MODE_SETTLE |-> cnt_q <= ST_LAST);
endmodule

// File: rtl/cm_io_steer.sv
module cm_io_steer
  import chan_mode_pkg::*;
(
  input  mode_t mode,
  input  logic  rx_level,
  input  logic  wake_level,
  output logic  drv_en,
  output logic  bias_en,
  output logic  rxd_out,
  output logic  rxd_pp_en
);
  always_comb begin
    drv_en    = 1'b0;
    bias_en   = 1'b0;
    rxd_out   = 1'b1;
    rxd_pp_en = 1'b0;
    unique case (mode)
      MODE_NORM: begin
        drv_en    = 1'b1;
        bias_en   = 1'b1;
        rxd_out   = rx_level;
        rxd_pp_en = 1'b1;
      end
      MODE_SETTLE: begin
        bias_en = 1'b1;
      end
      MODE_STBY: begin
        rxd_out   = wake_level;
        rxd_pp_en = ~wake_level;
      end
      default: ;
    endcase
  end

  // R3: when the pin is driven outside normal mode it is only ever driven low
  always_comb begin
    if (mode != MODE_NORM && rxd_pp_en)
      assert_pp_low_only_R3: assert (rxd_out == 1'b0);
  end
endmodule

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
  import chan_mode_pkg::*;
#(
  parameter int unsigned PWRUP_CYC  = 15000,
  parameter int unsigned SETTLE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       core_uv,
  input  logic       io_uv,
  input  logic       rx_level,
  input  logic       wake_level,
  output logic [1:0] mode,
  output logic       drv_en,
  output logic       bias_en,
  output logic       rxd_out,
  output logic       rxd_pp_en
);
  logic [2:0] raw_ctl, syn_ctl;
  logic       s_io_uv, s_core_uv, s_stby;
  mode_t      cur_mode;

  assign raw_ctl = {io_uv, core_uv, stby_req};

  cm_sync2 #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(syn_ctl)
  );

  assign {s_io_uv, s_core_uv, s_stby} = syn_ctl;

  cm_mode_fsm #(.PWRUP_CYC(PWRUP_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .s_io_uv(s_io_uv), .s_core_uv(s_core_uv), .s_stby(s_stby),
    .mode_q(cur_mode)
  );

  cm_io_steer u_steer (
    .mode(cur_mode), .rx_level(rx_level), .wake_level(wake_level),
    .drv_en(drv_en), .bias_en(bias_en), .rxd_out(rxd_out), .rxd_pp_en(rxd_pp_en)
  );

  assign mode = cur_mode;

  // R2: the driver is enabled only after the synchronised controls all read low
  assert_drv_needs_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> ($past(s_stby) == 1'b0 && $past(s_core_uv) == 1'b0 && $past(s_io_uv) == 1'b0));

  // R9: the mode cannot leave standby unless the synchronised request was low
  assert_sync_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && mode == 2'd2) |-> $past(s_stby) == 1'b0);
endmodule

// File: tb/chan_mode_ctrl_tb_top.sv
module chan_mode_ctrl_tb_top;
  localparam int PW = 6;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_req = 1'b1, core_uv = 1'b0, io_uv = 1'b0;
  logic rx_level = 1'b1, wake_level = 1'b1;
  logic [1:0] mode;
  logic drv_en, bias_en, rxd_out, rxd_pp_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_mode_ctrl #(.PWRUP_CYC(PW), .SETTLE_CYC(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .core_uv(core_uv), .io_uv(io_uv),
    .rx_level(rx_level), .wake_level(wake_level), .mode(mode), .drv_en(drv_en),
    .bias_en(bias_en), .rxd_out(rxd_out), .rxd_pp_en(rxd_pp_en)
  );

  function automatic logic [1:0] exp_mode(input logic iv, input logic cv, input logic sb);
    if (iv) return 2'd0;
    if (cv | sb) return 2'd1;
    return 2'd3;
  endfunction

  // {drv, bias, rxd, pp}
  function automatic logic [3:0] exp_out(input logic [1:0] m, input logic rx, input logic wk);
    case (m)
      2'd3: return {1'b1, 1'b1, rx, 1'b1};
      2'd2: return 4'b0110;
      2'd1: return {1'b0, 1'b0, wk, ~wk};
      default: return 4'b0010;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    for (int v = 0; v < 4; v++) begin
      rx_level = v[0];
      wake_level = v[1];
      #1;
      chk({4'd0, drv_en, bias_en, rxd_out, rxd_pp_en},
          {4'd0, exp_out(mode, v[0], v[1])}, tag);
    end
    rx_level = 1'b1;
    wake_level = 1'b1;
  endtask

  task automatic go_normal();
    io_uv = 1'b0; core_uv = 1'b0; stby_req = 1'b0;
    tick(PW + ST + 12);
  endtask

  initial begin
    tick(2);
    chk({6'd0, mode}, 8'd0, "R5 reset mode");
    chk({4'd0, drv_en, bias_en, rxd_out, rxd_pp_en}, 8'b0010, "R5 reset outputs");
    rst_n = 1'b1;
    // R8: power-up delay counted after the cleared flag passes the synchroniser
    tick(PW + 1);
    chk({6'd0, mode}, 8'd0, "R8 still unpowered on last count");
    tick(1);
    chk({6'd0, mode}, 8'd1, "R8 standby after power-up");
    chk_outs("R3 standby outputs");

    // R6: settling interval exact length
    stby_req = 1'b0;
    tick(2);
    chk({6'd0, mode}, 8'd1, "R9 standby before sync latency");
    tick(1);
    chk({6'd0, mode}, 8'd2, "R6 settling entered");
    chk_outs("R6 settling outputs");
    tick(ST - 1);
    chk({6'd0, mode}, 8'd2, "R6 settling last cycle");
    tick(1);
    chk({6'd0, mode}, 8'd3, "R6 normal after settling");
    chk_outs("R2 normal outputs");

    // R9: standby request takes effect on the third edge
    stby_req = 1'b1;
    tick(2);
    chk({6'd0, mode}, 8'd3, "R9 normal held two edges");
    tick(1);
    chk({6'd0, mode}, 8'd1, "R9 standby on third edge");

    // R7: abort settling by request and by core undervoltage
    stby_req = 1'b0;
    tick(4);
    chk({6'd0, mode}, 8'd2, "R7 settling before abort");
    stby_req = 1'b1;
    tick(3);
    chk({6'd0, mode}, 8'd1, "R7 request abort to standby");
    stby_req = 1'b0;
    tick(4);
    core_uv = 1'b1;
    tick(3);
    chk({6'd0, mode}, 8'd1, "R7 core undervoltage abort");
    tick(ST + 4);
    chk({6'd0, mode}, 8'd1, "R7 never reached normal");

    // R4: wake path alive under core undervoltage
    wake_level = 1'b0;
    #1;
    chk({6'd0, rxd_out, rxd_pp_en}, 8'b01, "R4 wake low reported");
    wake_level = 1'b1;
    core_uv = 1'b0;

    // R8: recovery from I/O undervoltage
    go_normal();
    io_uv = 1'b1;
    tick(3);
    chk({6'd0, mode}, 8'd0, "R5 unpowered on io undervoltage");
    io_uv = 1'b0;
    tick(2 + PW - 1);
    chk({6'd0, mode}, 8'd0, "R8 recovery last count");
    tick(1);
    chk({6'd0, mode}, 8'd1, "R8 recovery to standby");

    // R1: exhaustive priority sweep from normal
    for (int c = 0; c < 8; c++) begin
      go_normal();
      chk({6'd0, mode}, 8'd3, "R1 sweep start in normal");
      io_uv = c[2]; core_uv = c[1]; stby_req = c[0];
      tick(PW + ST + 10);
      chk({6'd0, mode}, {6'd0, exp_mode(c[2], c[1], c[0])}, "R1 priority");
      chk_outs("R5 R3 R2 outputs per mode");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule